// File: doc/BRIEF.md
# Display RAM Command and Access Controller

This block sits between a byte-wide host bus and the frame store of a small graphic display. Each host transfer carries a data/command flag and a read/write flag. Command bytes move the page and column pointers, save or restore the column pointer, arm a bulk clear of either the graphic area or the icon row, and set two oscillator control bits. Data bytes go into the frame store or come out of it at the current page and column. The column pointer steps by one after every data access and returns to zero after the last column.

The frame store is organised as `GFX_PAGES` graphic pages of `COLS` bytes each. Each byte holds eight vertically stacked pixels, so the default is 8 pages for 64 rows by 128 columns. One more page, at index `GFX_PAGES`, holds the icon row. A bulk clear is armed by a command byte and starts on the next data write. That write is a dummy: its byte is not stored and the column pointer does not move. The clear then writes zeros at one byte per clock and raises `busy`. The host bus is ignored while `busy` is high.

A separate scan read port lets the panel refresh logic fetch bytes at any time. Host reads and writes do not depend on scanning, and the frame store may be changed while it is being shown.

Top module: `disp_ram_ctrl`

## Requirements
- R1: A transfer is accepted on a rising clock edge where `host_valid`=1 and `busy`=0. Its type comes from {`host_dc`,`host_rw`}: 00 is a command write, 10 a data write and 11 a data read. 01 is a command read; it is invalid and changes no state and returns no data.
- R2: A data write stores `host_wdata` at (page, column). A data read drives the stored byte on `host_rdata`, with `host_rvalid` high for exactly the cycle after acceptance. Both advance the column pointer by one. No command except the column load and the restore changes the column pointer.
- R3: When a data access is made at column `COLS`-1, the column pointer wraps to 0.
- R4: A command byte with bit 7 = 1 loads bits 6:0 into the column pointer. A command byte with bits 7:4 = 0000 loads bits 3:0 into the page register.
- R5: Command 0x34 copies the column pointer into a save register. Command 0x35 copies the save register into the column pointer. The save register resets to 0, so a restore issued before any save selects column 0.
- R6: Command 0x3C (end of command) cancels a pending clear and leaves both pointers unchanged.
- R7: Command 0x36 arms a graphic clear. The next data write is a dummy: its byte is not stored and the column pointer does not move. Pages 0 to `GFX_PAGES`-1 are then zeroed and `busy` stays high for `GFX_PAGES`*`COLS` cycles. The icon page is not touched.
- R8: Command 0x37 arms an icon clear only while the page register equals `GFX_PAGES`. The following dummy write then zeros that page alone, with `busy` high for `COLS` cycles. With any other page selected, 0x37 has no effect.
- R9: While `busy` is high, every host transfer is ignored. This includes commands that would change a pointer or an oscillator bit.
- R10: Commands 0x7A/0x7B set `osc_ext_sel` to bit 0 of the byte. Commands 0x7E/0x7F set `osc_enable` to bit 0 of the byte. Both bits reset to 0.
- R11: With the page register above `GFX_PAGES`, data writes are dropped and data reads return 0x00. Both still advance the column pointer.
- R12: `scan_data` shows the byte at (`scan_page`, `scan_col`) one cycle after the address is applied, and 0x00 for a page above `GFX_PAGES`. A host write is visible on the scan port on the cycle after it lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host transfer request |
| host_dc | input | 1 | 1 = data, 0 = command |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_wdata | input | 8 | Command or data byte from host |
| host_rdata | output | 8 | Read data to host |
| host_rvalid | output | 1 | `host_rdata` valid this cycle |
| busy | output | 1 | Bulk clear in progress; host ignored |
| osc_ext_sel | output | 1 | Oscillator source select bit |
| osc_enable | output | 1 | Oscillator on/off bit |
| scan_page | input | 4 | Scan read page |
| scan_col | input | 7 | Scan read column (log2 `COLS` bits) |
| scan_data | output | 8 | Scan read byte |

## Verification
The hardest state to reach is the dummy byte after a clear command. It must neither land in memory nor move the column pointer, and the pointer itself cannot be seen at the ports. The stimulus places a marker byte just before the arming command. It sends further commands that would move the pointer while `busy` is high. After the clear it writes a second marker without setting a column, and reads back where that marker landed. The icon clear is also armed with the wrong page selected, to show that the guard leaves the next write as a normal write.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

   typedef enum logic [1:0] {
      ACC_CMD_WR = 2'b00,
      ACC_CMD_RD = 2'b01,
      ACC_DAT_WR = 2'b10,
      ACC_DAT_RD = 2'b11
   } access_e;

   typedef enum logic [3:0] {
      OP_NONE     = 4'd0,
      OP_SET_COL  = 4'd1,
      OP_SET_PAGE = 4'd2,
      OP_END      = 4'd3,
      OP_SAVE     = 4'd4,
      OP_RESTORE  = 4'd5,
      OP_CLR_GFX  = 4'd6,
      OP_CLR_ICON = 4'd7,
      OP_OSC_SEL  = 4'd8,
      OP_OSC_PWR  = 4'd9
   } cmd_op_e;

   typedef enum logic [1:0] {
      ARM_NONE = 2'd0,
      ARM_GFX  = 2'd1,
      ARM_ICON = 2'd2
   } arm_e;

   typedef struct packed {
      cmd_op_e    op;
      logic [6:0] arg;
   } cmd_t;

   localparam logic [7:0] BYTE_END      = 8'h3C;
   localparam logic [7:0] BYTE_CLR_GFX  = 8'h36;
   localparam logic [7:0] BYTE_CLR_ICON = 8'h37;
   localparam logic [6:0] PFX_SAVE_RST  = 7'b0011010;
   localparam logic [6:0] PFX_OSC_SEL   = 7'b0111101;
   localparam logic [6:0] PFX_OSC_PWR   = 7'b0111111;

endpackage

// File: rtl/dram_cmd_decode.sv
module dram_cmd_decode
   import dram_ctrl_pkg::*;
(
   input  logic [7:0] cmd_byte,
   output cmd_t       cmd
);

   always_comb begin
      cmd.arg = cmd_byte[6:0];
      cmd.op  = OP_NONE;
      if (cmd_byte[7]) begin
         cmd.op = OP_SET_COL;
      end else if (cmd_byte[7:4] == 4'b0000) begin
         cmd.op = OP_SET_PAGE;
      end else if (cmd_byte == BYTE_END) begin
         cmd.op = OP_END;
      end else if (cmd_byte[7:1] == PFX_SAVE_RST) begin
         cmd.op = cmd_byte[0] ? OP_RESTORE : OP_SAVE;
      end else if (cmd_byte == BYTE_CLR_GFX) begin
         cmd.op = OP_CLR_GFX;
      end else if (cmd_byte == BYTE_CLR_ICON) begin
         cmd.op = OP_CLR_ICON;
      end else if (cmd_byte[7:1] == PFX_OSC_SEL) begin
         cmd.op = OP_OSC_SEL;
      end else if (cmd_byte[7:1] == PFX_OSC_PWR) begin
         cmd.op = OP_OSC_PWR;
      end
   end

endmodule

// File: rtl/dram_col_ptr.sv
module dram_col_ptr #(
   parameter int COLS  = 128,
   parameter int COL_W = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_en,
   input  logic [6:0]       load_val,
   input  logic             inc_en,
   input  logic             save_en,
   input  logic             restore_en,
   output logic [COL_W-1:0] col
);

   localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

   logic [COL_W-1:0] col_q;
   logic [COL_W-1:0] saved_q;
   logic [COL_W-1:0] col_inc;
   logic [COL_W-1:0] load_fit;

   generate
      if (COLS == (1 << COL_W)) begin : g_pow2
         assign col_inc  = col_q + 1'b1;
         assign load_fit = load_val[COL_W-1:0];
      end else begin : g_cmp
         assign col_inc  = (col_q == LAST_COL) ? '0 : col_q + 1'b1;
         assign load_fit = (load_val >= 7'(COLS)) ? LAST_COL : load_val[COL_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q   <= '0;
         saved_q <= '0;
      end else begin
         if (load_en) begin
            col_q <= load_fit;
         end else if (restore_en) begin
            col_q <= saved_q;
         end else if (inc_en) begin
            col_q <= col_inc;
         end
         if (save_en) begin
            saved_q <= col_q;
         end
      end
   end

   assign col = col_q;

   // R3: overflow returns to column zero
   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_en && !load_en && !restore_en && col_q == LAST_COL) |=> (col_q == '0));

   // R5: restore brings back the saved column
   p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (restore_en && !load_en) |=> (col_q == $past(saved_q)));

   // R2: pointer holds when nothing moves it
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_en && !inc_en && !restore_en) |=> $stable(col_q));

endmodule

// File: rtl/dram_clear_engine.sv
module dram_clear_engine #(
   parameter int COLS      = 128,
   parameter int GFX_PAGES = 8,
   parameter int ADDR_W    = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_gfx,
   input  logic              start_icon,
   output logic              busy,
   output logic              clr_we,
   output logic [ADDR_W-1:0] clr_addr
);

   localparam int GFX_CELLS = GFX_PAGES * COLS;
   localparam int DEPTH     = GFX_CELLS + COLS;
   localparam int CNT_W     = $clog2(GFX_CELLS + 1);

   logic              busy_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  last_q;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         last_q <= '0;
         base_q <= '0;
      end else if (!busy_q && (start_gfx || start_icon)) begin
         busy_q <= 1'b1;
         cnt_q  <= '0;
         if (start_gfx) begin
            base_q <= '0;
            last_q <= CNT_W'(GFX_CELLS - 1);
         end else begin
            base_q <= ADDR_W'(GFX_CELLS);
            last_q <= CNT_W'(COLS - 1);
         end
      end else if (busy_q) begin
         if (cnt_q == last_q) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign clr_we   = busy_q;
   assign clr_addr = base_q + ADDR_W'(cnt_q);

   // R7: clear never addresses beyond the store
   p_clr_bounds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (int'(clr_addr) < DEPTH));

   // R9: no new clear is requested while one runs
   p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !(start_gfx || start_icon));

endmodule

// File: rtl/dram_store.sv
module dram_store #(
   parameter int DEPTH     = 1152,
   parameter int ADDR_W    = 11,
   parameter bit SCAN_PORT = 1'b1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [7:0]        rdata,
   input  logic [ADDR_W-1:0] saddr,
   output logic [7:0]        sdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      if (re) begin
         rdata <= mem[raddr];
      end
   end

   generate
      if (SCAN_PORT) begin : g_scan
         always_ff @(posedge clk) begin
            sdata <= mem[saddr];
         end
      end else begin : g_noscan
         logic unused_saddr;
         assign unused_saddr = ^saddr;
         assign sdata = 8'h00;
      end
   endgenerate

endmodule

// File: rtl/disp_ram_ctrl.sv
module disp_ram_ctrl
   import dram_ctrl_pkg::*;
#(
   parameter int COLS      = 128,
   parameter int GFX_PAGES = 8,
   parameter bit SCAN_PORT = 1'b1,
   parameter int COL_W     = $clog2(COLS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_valid,
   input  logic             host_dc,
   input  logic             host_rw,
   input  logic [7:0]       host_wdata,
   output logic [7:0]       host_rdata,
   output logic             host_rvalid,
   output logic             busy,
   output logic             osc_ext_sel,
   output logic             osc_enable,
   input  logic [3:0]       scan_page,
   input  logic [COL_W-1:0] scan_col,
   output logic [7:0]       scan_data
);

   localparam int         DEPTH     = (GFX_PAGES + 1) * COLS;
   localparam int         ADDR_W    = $clog2(DEPTH);
   localparam logic [3:0] ICON_PAGE = 4'(GFX_PAGES);

   generate
      if (COLS < 2 || COLS > 128) begin : g_bad_cols
         $error("COLS must lie in 2..128");
      end
      if (GFX_PAGES < 1 || GFX_PAGES > 15) begin : g_bad_pages
         $error("GFX_PAGES must lie in 1..15");
      end
   endgenerate

   access_e           acc;
   cmd_t              cmd;
   arm_e              arm_q;
   logic [3:0]        page_q;
   logic [COL_W-1:0]  col_q;
   logic              osc_ext_q, osc_on_q;
   logic              rvalid_q, rd_oor_q, scan_oor_q;
   logic              accept, cmd_wr, dat_wr, dat_rd, dummy;
   logic              page_ok, scan_ok;
   logic [ADDR_W-1:0] host_addr, scan_addr, clr_addr, st_waddr;
   logic [7:0]        st_wdata, st_rdata, st_sdata;
   logic              st_we, clr_we, clr_busy;

   assign acc     = access_e'({host_dc, host_rw});
   assign accept  = host_valid && !clr_busy;
   assign cmd_wr  = accept && (acc == ACC_CMD_WR);
   assign dat_wr  = accept && (acc == ACC_DAT_WR);
   assign dat_rd  = accept && (acc == ACC_DAT_RD);
   assign dummy   = dat_wr && (arm_q != ARM_NONE);
   assign page_ok = (page_q <= ICON_PAGE);
   assign scan_ok = (scan_page <= ICON_PAGE);

   dram_cmd_decode u_dec (
      .cmd_byte (host_wdata),
      .cmd      (cmd)
   );

   dram_col_ptr #(.COLS(COLS), .COL_W(COL_W)) u_col (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_en    (cmd_wr && cmd.op == OP_SET_COL),
      .load_val   (cmd.arg),
      .inc_en     (dat_rd || (dat_wr && !dummy)),
      .save_en    (cmd_wr && cmd.op == OP_SAVE),
      .restore_en (cmd_wr && cmd.op == OP_RESTORE),
      .col        (col_q)
   );

   dram_clear_engine #(.COLS(COLS), .GFX_PAGES(GFX_PAGES), .ADDR_W(ADDR_W)) u_clr (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_gfx  (dummy && arm_q == ARM_GFX),
      .start_icon (dummy && arm_q == ARM_ICON),
      .busy       (clr_busy),
      .clr_we     (clr_we),
      .clr_addr   (clr_addr)
   );

   assign host_addr = ADDR_W'(page_q) * ADDR_W'(COLS) + ADDR_W'(col_q);
   assign scan_addr = ADDR_W'(scan_page) * ADDR_W'(COLS) + ADDR_W'(scan_col);

   always_comb begin
      if (clr_we) begin
         st_we    = 1'b1;
         st_waddr = clr_addr;
         st_wdata = 8'h00;
      end else begin
         st_we    = dat_wr && !dummy && page_ok;
         st_waddr = host_addr;
         st_wdata = host_wdata;
      end
   end

   dram_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SCAN_PORT(SCAN_PORT)) u_store (
      .clk   (clk),
      .we    (st_we),
      .waddr (st_waddr),
      .wdata (st_wdata),
      .re    (dat_rd && page_ok),
      .raddr (host_addr),
      .rdata (st_rdata),
      .saddr (scan_addr),
      .sdata (st_sdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q     <= '0;
         arm_q      <= ARM_NONE;
         osc_ext_q  <= 1'b0;
         osc_on_q   <= 1'b0;
         rvalid_q   <= 1'b0;
         rd_oor_q   <= 1'b0;
         scan_oor_q <= 1'b0;
      end else begin
         rvalid_q   <= dat_rd;
         scan_oor_q <= !scan_ok;
         if (dat_rd) begin
            rd_oor_q <= !page_ok;
         end
         if (dummy) begin
            arm_q <= ARM_NONE;
         end
         if (cmd_wr) begin
            case (cmd.op)
               OP_SET_PAGE: page_q <= cmd.arg[3:0];
               OP_END:      arm_q  <= ARM_NONE;
               OP_CLR_GFX:  arm_q  <= ARM_GFX;
               OP_CLR_ICON: if (page_q == ICON_PAGE) arm_q <= ARM_ICON;
               OP_OSC_SEL:  osc_ext_q <= cmd.arg[0];
               OP_OSC_PWR:  osc_on_q  <= cmd.arg[0];
               default:     ;
            endcase
         end
      end
   end

   assign host_rdata  = rd_oor_q ? 8'h00 : st_rdata;
   assign host_rvalid = rvalid_q;
   assign busy        = clr_busy;
   assign osc_ext_sel = osc_ext_q;
   assign osc_enable  = osc_on_q;
   assign scan_data   = scan_oor_q ? 8'h00 : st_sdata;

   // R1: command read leaves every register alone and returns nothing
   p_cmd_read_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && acc == ACC_CMD_RD) |=>
         (!host_rvalid && $stable(page_q) && $stable(arm_q) && $stable(osc_on_q) && $stable(osc_ext_q)));

   // R2: an accepted data read answers on the next cycle
   p_read_answers_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rd |=> host_rvalid);

   // R7: the dummy write launches the clear
   p_dummy_starts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dummy |=> busy);

   // R8: icon clear is not armed on the wrong page
   p_icon_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd.op == OP_CLR_ICON && page_q != ICON_PAGE) |=> (arm_q == $past(arm_q)));

   // R9: host is locked out while clearing
   p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(page_q) && $stable(osc_on_q) && $stable(osc_ext_q) && $stable(col_q) && !host_rvalid));

endmodule

// File: tb/disp_ram_ctrl_tb_top.sv
module disp_ram_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_valid = 1'b0;
   logic       host_dc = 1'b0;
   logic       host_rw = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       host_rvalid;
   logic       busy;
   logic       osc_ext_sel;
   logic       osc_enable;
   logic [3:0] scan_page = 4'd0;
   logic [6:0] scan_col = 7'd0;
   logic [7:0] scan_data;

   int n_chk = 0;
   int n_fail = 0;
   int busy_cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   disp_ram_ctrl dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_valid  (host_valid),
      .host_dc     (host_dc),
      .host_rw     (host_rw),
      .host_wdata  (host_wdata),
      .host_rdata  (host_rdata),
      .host_rvalid (host_rvalid),
      .busy        (busy),
      .osc_ext_sel (osc_ext_sel),
      .osc_enable  (osc_enable),
      .scan_page   (scan_page),
      .scan_col    (scan_col),
      .scan_data   (scan_data)
   );

   always @(negedge clk) if (busy) busy_cycles++;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic op(input logic dc, input logic rw, input logic [7:0] b);
      host_valid = 1'b1; host_dc = dc; host_rw = rw; host_wdata = b;
      @(negedge clk);
      host_valid = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] b);  op(1'b0, 1'b0, b); endtask
   task automatic wr(input logic [7:0] b);   op(1'b1, 1'b0, b); endtask

   task automatic rd(output logic [7:0] d, output logic v);
      op(1'b1, 1'b1, 8'h00);
      d = host_rdata; v = host_rvalid;
   endtask

   task automatic set_pos(input logic [3:0] pg, input logic [6:0] c);
      cmd({4'b0000, pg});
      cmd({1'b1, c});
   endtask

   task automatic expect_at(input string tag, input logic [3:0] pg, input logic [6:0] c, input logic [7:0] exp);
      logic [7:0] d; logic v;
      set_pos(pg, c);
      rd(d, v);
      check(tag, int'(v), 1);
      check(tag, int'(d), int'(exp));
   endtask

   task automatic wait_idle();
      int guard = 0;
      while (busy && guard < 5000) begin
         guard++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      check("R10 osc_ext reset", int'(osc_ext_sel), 0);
      check("R10 osc_en reset", int'(osc_enable), 0);
      check("R9 busy reset", int'(busy), 0);
      check("R2 rvalid reset", int'(host_rvalid), 0);
   endtask

   task automatic t_restore_first();
      set_pos(4'd2, 7'd40);
      cmd(8'h35);
      wr(8'hB0);
      expect_at("R5 restore before save", 4'd2, 7'd0, 8'hB0);
   endtask

   task automatic t_save_restore();
      set_pos(4'd2, 7'd30);
      cmd(8'h34);
      cmd(8'h80 | 8'd90);
      cmd(8'h35);
      cmd(8'h3C);
      wr(8'hB1);
      expect_at("R5 save restore", 4'd2, 7'd30, 8'hB1);
   endtask

   task automatic t_write_read();
      logic [7:0] d; logic v;
      set_pos(4'd3, 7'd0);
      for (int i = 0; i < 4; i++) wr(8'h10 + 8'(i * 17));
      cmd(8'h80);
      for (int i = 0; i < 4; i++) begin
         rd(d, v);
         check("R2 rvalid", int'(v), 1);
         check("R2 burst read", int'(d), int'(8'h10 + 8'(i * 17)));
      end
      @(negedge clk);
      check("R2 rvalid one cycle", int'(host_rvalid), 0);
   endtask

   task automatic t_cmd_no_move();
      set_pos(4'd3, 7'd5);
      wr(8'h5A);
      cmd(8'h03);
      cmd(8'h7B);
      cmd(8'h76);
      cmd(8'h3C);
      wr(8'hC6);
      expect_at("R2 commands keep column", 4'd3, 7'd6, 8'hC6);
      check("R10 osc_ext set", int'(osc_ext_sel), 1);
      cmd(8'h7A);
      check("R10 osc_ext clear", int'(osc_ext_sel), 0);
      cmd(8'h7F);
      check("R10 osc_en set", int'(osc_enable), 1);
      cmd(8'h7E);
      check("R10 osc_en clear", int'(osc_enable), 0);
   endtask

   task automatic t_cmd_read();
      set_pos(4'd3, 7'd20);
      op(1'b0, 1'b1, 8'h85);
      check("R1 no rvalid", int'(host_rvalid), 0);
      op(1'b0, 1'b1, 8'h7F);
      check("R1 osc untouched", int'(osc_enable), 0);
      op(1'b0, 1'b1, 8'h07);
      wr(8'hD1);
      expect_at("R1 column and page kept", 4'd3, 7'd20, 8'hD1);
      expect_at("R4 neighbour kept", 4'd3, 7'd5, 8'h5A);
   endtask

   task automatic t_wrap();
      logic [7:0] d; logic v;
      set_pos(4'd1, 7'd127);
      wr(8'hA1);
      wr(8'hA2);
      expect_at("R3 write wrap", 4'd1, 7'd0, 8'hA2);
      set_pos(4'd1, 7'd127);
      rd(d, v);
      check("R3 last column", int'(d), 8'hA1);
      rd(d, v);
      check("R3 read wrap", int'(d), 8'hA2);
   endtask

   task automatic t_end_cancels();
      set_pos(4'd4, 7'd8);
      cmd(8'h36);
      cmd(8'h3C);
      wr(8'h55);
      check("R6 no clear after end", int'(busy), 0);
      expect_at("R6 write stored", 4'd4, 7'd8, 8'h55);
   endtask

   task automatic t_icon_wrong_page();
      set_pos(4'd4, 7'd9);
      cmd(8'h37);
      wr(8'h44);
      check("R8 wrong page no clear", int'(busy), 0);
      wr(8'h45);
      expect_at("R8 normal write", 4'd4, 7'd9, 8'h44);
      expect_at("R8 column advanced", 4'd4, 7'd10, 8'h45);
   endtask

   task automatic t_out_of_range();
      set_pos(4'd12, 7'd20);
      wr(8'h99);
      cmd(8'h00);
      wr(8'h66);
      expect_at("R11 column advanced", 4'd0, 7'd21, 8'h66);
      expect_at("R11 read zero", 4'd12, 7'd20, 8'h00);
   endtask

   task automatic t_scan();
      scan_page = 4'd5; scan_col = 7'd2;
      set_pos(4'd5, 7'd2);
      wr(8'h3E);
      @(negedge clk);
      check("R12 scan sees write", int'(scan_data), 8'h3E);
      wr(8'h3F);
      @(negedge clk);
      check("R12 scan unchanged by other column", int'(scan_data), 8'h3E);
      scan_page = 4'd13;
      @(negedge clk);
      @(negedge clk);
      check("R12 scan out of range", int'(scan_data), 0);
   endtask

   task automatic t_icon_clear();
      set_pos(4'd8, 7'd0);
      wr(8'h77);
      wr(8'h78);
      set_pos(4'd0, 7'd0);
      wr(8'h33);
      set_pos(4'd8, 7'd50);
      cmd(8'h37);
      busy_cycles = 0;
      wr(8'hEE);
      check("R8 busy after dummy", int'(busy), 1);
      op(1'b0, 1'b0, 8'h7B);
      wait_idle();
      check("R8 icon clear length", busy_cycles, 128);
      check("R9 osc_ext ignored", int'(osc_ext_sel), 0);
      expect_at("R8 icon zeroed", 4'd8, 7'd0, 8'h00);
      expect_at("R8 icon zeroed", 4'd8, 7'd1, 8'h00);
      expect_at("R8 graphic kept", 4'd0, 7'd0, 8'h33);
   endtask

   task automatic t_gfx_clear();
      set_pos(4'd8, 7'd3);
      wr(8'h5A);
      set_pos(4'd6, 7'd10);
      wr(8'h11);
      cmd(8'h36);
      busy_cycles = 0;
      wr(8'hEE);
      check("R7 busy after dummy", int'(busy), 1);
      cmd(8'h7F);
      cmd(8'h80 | 8'd100);
      cmd(8'h02);
      op(1'b1, 1'b0, 8'hCC);
      wait_idle();
      check("R7 graphic clear length", busy_cycles, 1024);
      check("R9 osc_en ignored", int'(osc_enable), 0);
      wr(8'h22);
      expect_at("R7 dummy did not advance", 4'd6, 7'd11, 8'h22);
      expect_at("R7 graphic zeroed", 4'd6, 7'd10, 8'h00);
      expect_at("R7 graphic zeroed", 4'd0, 7'd0, 8'h00);
      expect_at("R7 icon kept", 4'd8, 7'd3, 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_restore_first();
      t_save_restore();
      t_write_read();
      t_cmd_no_move();
      t_cmd_read();
      t_wrap();
      t_end_cancels();
      t_icon_wrong_page();
      t_out_of_range();
      t_scan();
      t_icon_clear();
      t_gfx_clear();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule